// File: doc/BRIEF.md
# Interconnect Test Code Generator

This block produces the parallel test vectors that drive a set of N board nets during an interconnect test, and checks what comes back. Every net is given its own serial code word. Each test step puts one bit from every net's word onto the drive vector at the same time, so a test of length L is a sequence of L parallel vectors. Five code families can be selected when a test is started: plain binary counting, counting that never uses the all-zero or all-one words, counting followed by its complement, the same with a fixed two-bit prefix, and a single walking one.

A controller pulses `start` with a mode code and then advances the test with `step`, one pulse per vector. With each step it also presents on `sense` what the receivers picked up for the vector currently on `drive`. The block compares the two and keeps a sticky mismatch flag per net. The number of vectors in the chosen scheme is shown on `test_len` for the whole test. A one-cycle `done` pulse marks the acceptance of the last vector.

Top module: `icode_gen`

## Requirements
- R1: After reset `busy`, `done` and every bit of `fault` are 0. Whenever `busy` is 0, `drive` is all zeros.
- R2: Mode code 0 (counting): net i carries the binary value of i as a word of C = ceil(log2 N) bits, and `test_len` is C.
- R3: Mode code 1 (modified counting): net i carries the value i+1 as a word of M = ceil(log2(N+2)) bits, so no net ever has an all-zero or all-one word, and `test_len` is M.
- R4: Mode code 2 (true/complement): net i carries the C-bit counting word followed by its bitwise complement. `test_len` is 2C, and every net is driven high in exactly C of the vectors.
- R5: Mode code 3 (extended true/complement): each word starts with a 0 and then a 1, followed by the true/complement word. `test_len` is 2C+2.
- R6: Mode code 4 (walking one): vector k drives a 1 on net k only, and `test_len` is N.
- R7: Words are sent most significant bit first. Vector k (counted from 0) is on `drive` from the start until the k-th accepted step. `drive` only changes on `start` or on an accepted step. A step while `busy` is 0 has no effect.
- R8: On each accepted step, `fault[i]` is set if `sense[i]` differs from `drive[i]`. Flags stay set until the next `start`, which clears all of them.
- R9: The step that accepts the last vector clears `busy` and makes `done` high for exactly one cycle in the following cycle.
- R10: `mode` is latched at `start`. Unused codes 5 to 7 run the counting scheme. `test_len` holds its value from the cycle after `start` until `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new test with the scheme given on `mode` |
| mode | input | 3 | Code-family selector, sampled at `start` |
| step | input | 1 | Accept the current vector and its sensed response |
| busy | output | 1 | A test is in progress |
| drive | output | N | Current parallel test vector |
| sense | input | N | Received vector for the current `drive` |
| fault | output | N | Sticky per-net mismatch flags |
| test_len | output | LW | Number of vectors in the running scheme |
| done | output | 1 | One-cycle pulse after the last vector is accepted |

## Verification
Every mode code is run on a six-net instance. Six is not a power of two, so the counting widths C=3 and M=3 are each checked against an arithmetic model. Each vector is compared with that model. The per-net count of ones tells apart a wrong complement half in the true/complement schemes. Each scheme is run once with sense equal to drive and once with a single flipped bit. This separates a correct flag from a flag that is set on the wrong net, set on every step, or left uncleared by the next start. Steps issued while idle and the cycle placement of `done` are checked between runs.

// File: rtl/icode_gen.sv
module icode_gen #(
  parameter int N = 8,
  localparam int CB = $clog2(N),
  localparam int MB = $clog2(N + 2),
  localparam int LW = $clog2(N + 2 * MB + 3) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic          step,
  output logic          busy,
  output logic [N-1:0]  drive,
  input  logic [N-1:0]  sense,
  output logic [N-1:0]  fault,
  output logic [LW-1:0] test_len,
  output logic          done
);
  localparam logic [2:0] M_CNT  = 3'd0;
  localparam logic [2:0] M_MOD  = 3'd1;
  localparam logic [2:0] M_TC   = 3'd2;
  localparam logic [2:0] M_ETC  = 3'd3;
  localparam logic [2:0] M_WALK = 3'd4;

  logic          busy_q, done_q;
  logic [2:0]    mode_q;
  logic [LW-1:0] idx_q, len_q;
  logic [N-1:0]  fault_q;
  logic          acc;

  function automatic logic [2:0] norm_mode(input logic [2:0] m);
    return (m > M_WALK) ? M_CNT : m;
  endfunction

  function automatic logic [LW-1:0] len_of(input logic [2:0] m);
    case (m)
      M_MOD:   return LW'(MB);
      M_TC:    return LW'(2 * CB);
      M_ETC:   return LW'(2 * CB + 2);
      M_WALK:  return LW'(N);
      default: return LW'(CB);
    endcase
  endfunction

  function automatic logic tc_bit(input int i, input int k);
    if (k < CB) return 1'((i >>> (CB - 1 - k)) & 1);
    else        return !(1'((i >>> (2 * CB - 1 - k)) & 1));
  endfunction

  function automatic logic code_bit(input int i, input int k, input logic [2:0] m);
    case (m)
      M_MOD:   return (MB - 1 - k >= 0) ? 1'(((i + 1) >>> (MB - 1 - k)) & 1) : 1'b0;
      M_TC:    return tc_bit(i, k);
      M_ETC:   return (k < 2) ? (k == 1) : tc_bit(i, k - 2);
      M_WALK:  return i == k;
      default: return (CB - 1 - k >= 0) ? 1'((i >>> (CB - 1 - k)) & 1) : 1'b0;
    endcase
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_net
    assign drive[g] = busy_q & code_bit(g, int'(idx_q), mode_q);
  end

  assign acc = step & busy_q & ~start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      mode_q  <= M_CNT;
      idx_q   <= '0;
      len_q   <= '0;
      fault_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q  <= 1'b1;
        mode_q  <= norm_mode(mode);
        len_q   <= len_of(norm_mode(mode));
        idx_q   <= '0;
        fault_q <= '0;
      end else if (acc) begin
        fault_q <= fault_q | (sense ^ drive);
        if (idx_q == len_q - 1'b1) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign fault    = fault_q;
  assign test_len = len_q;
endmodule

module icode_gen_chk #(
  parameter int N = 8,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          step,
  input logic          busy,
  input logic [N-1:0]  drive,
  input logic [N-1:0]  fault,
  input logic [LW-1:0] test_len,
  input logic          done,
  input logic [2:0]    mode_q
);
  // R1
  idle_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> drive == '0);

  // R6
  walk_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == 3'd4) |-> $countones(drive) == 1);

  // R7
  drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step && !start) |=> $stable(drive));

  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ((fault & $past(fault)) == $past(fault)));

  // R8
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> fault == '0);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && $past(step) && !busy));

  // R10
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> $stable(test_len));
endmodule

bind icode_gen icode_gen_chk #(.N(N), .LW(LW)) u_chk (.*);

// File: tb/tb_icode_gen.sv
module tb_icode_gen;
  localparam int NB  = 6;
  localparam int CBT = $clog2(NB);
  localparam int MBT = $clog2(NB + 2);
  localparam int LWB = $clog2(NB + 2 * MBT + 3) + 1;

  logic clk = 0, rst_n = 0, start = 0, step = 0;
  logic [2:0] mode = 0;
  logic [NB-1:0] sense = 0;
  logic busy, done;
  logic [NB-1:0] drive, fault;
  logic [LWB-1:0] test_len;

  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  icode_gen #(.N(NB)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .step(step),
    .busy(busy), .drive(drive), .sense(sense), .fault(fault),
    .test_len(test_len), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_mode(int m);
    return (m > 4) ? 0 : m;
  endfunction

  function automatic int exp_len(int m);
    case (eff_mode(m))
      1: return MBT;
      2: return 2 * CBT;
      3: return 2 * CBT + 2;
      4: return NB;
      default: return CBT;
    endcase
  endfunction

  function automatic int digit(int v, int w, int k);
    return (v / (1 << (w - 1 - k))) % 2;
  endfunction

  function automatic int ebit(int m, int i, int k);
    case (eff_mode(m))
      1: return digit(i + 1, MBT, k);
      2: return (k < CBT) ? digit(i, CBT, k) : 1 - digit(i, CBT, k - CBT);
      3: begin
        if (k < 2) return k;
        return (k - 2 < CBT) ? digit(i, CBT, k - 2) : 1 - digit(i, CBT, k - 2 - CBT);
      end
      4: return (i == k) ? 1 : 0;
      default: return digit(i, CBT, k);
    endcase
  endfunction

  function automatic string rtag(int m);
    case (eff_mode(m))
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic run(input int m, input bit inject);
    int len;
    int fnet, fstep;
    int ones [NB];
    logic [NB-1:0] expv, expf;
    len = exp_len(m);
    fnet = m % NB;
    fstep = m % len;
    expf = '0;
    for (int i = 0; i < NB; i++) ones[i] = 0;
    @(negedge clk);
    mode = 3'(m); start = 1;
    @(negedge clk);
    start = 0;
    mode = 3'(7 - m);
    // R10 length and R8 flags cleared by start
    chk(test_len == LWB'(len), "R10 len", test_len, len);
    chk(busy == 1'b1, "R7 busy", busy, 1);
    chk(fault == '0, "R8 clear", fault, 0);
    for (int k = 0; k < len; k++) begin
      for (int i = 0; i < NB; i++) expv[i] = ebit(m, i, k) != 0;
      chk(drive == expv, rtag(m), drive, expv);
      for (int i = 0; i < NB; i++) ones[i] += int'(drive[i]);
      sense = drive;
      if (inject && k == fstep) begin
        sense[fnet] = ~drive[fnet];
        expf[fnet] = 1'b1;
      end
      step = 1;
      @(negedge clk);
      step = 0;
      if (k < len - 1) chk(done == 1'b0, "R9 early", done, 0);
    end
    chk(done == 1'b1, "R9 done", done, 1);
    chk(busy == 1'b0, "R9 busy", busy, 0);
    chk(fault == expf, "R8 flags", fault, expf);
    chk(drive == '0, "R1 idle drive", drive, 0);
    if (eff_mode(m) == 2 || eff_mode(m) == 3)
      for (int i = 0; i < NB; i++)
        chk(ones[i] == len / 2, "R4 balance", ones[i], len / 2);
    // R7 step while idle has no effect
    sense = ~sense;
    step = 1;
    @(negedge clk);
    step = 0;
    chk(done == 1'b0, "R9 single", done, 0);
    chk(busy == 1'b0 && drive == '0, "R7 idle step", drive, 0);
    chk(fault == expf, "R7 idle flags", fault, expf);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(fault == '0, "R1 fault", fault, 0);
    chk(drive == '0, "R1 drive", drive, 0);
    rst_n = 1;
    for (int pass = 0; pass < 2; pass++)
      for (int m = 0; m < 8; m++)
        run(m, pass == 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule